// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave end of a 128-byte serial EEPROM on a two-wire bus. Both bus lines arrive as open-drain inputs. The block pulls SDA low through a single enable output and never drives it high. Each line passes through a synchroniser and an edge detector, all clocked by the system clock. The control logic then finds start and stop conditions, shifts bytes in and out on the SCL edges, and acknowledges every byte that it receives.

There is no separate device-select byte. The first byte after a start carries a 7-bit word address in its upper bits and the transfer direction in its least significant bit. A write places up to one page of four data bytes into a staging buffer. The staged bytes go into the storage array only when the stop arrives, and a timed internal write cycle follows. For the length of that cycle the slave stays off the bus. A read returns bytes from the addressed location onward, for as long as the master keeps acknowledging them.

Top module: `eeprom2w_slave`

## Requirements
- R1: After reset and until the first start condition, the slave never pulls SDA low. A byte clocked in without a preceding start gets no acknowledge.
- R2: In the first byte after a start, bits 7 to 1 (sent MSB first) are the word address and bit 0 is the direction, where 1 means read. The slave acknowledges the address byte and every write data byte by holding SDA low for the whole of the ninth SCL high period.
- R3: A byte write (address with direction 0, one data byte, then stop) stores that byte at the given address. The new value can be read back once the write cycle is over.
- R4: After each data byte of a write, only the low 2 address bits advance and the upper 5 stay fixed, so a write never leaves its 4-byte page. When more than 4 bytes are sent, the address wraps inside the page and later bytes overwrite earlier ones.
- R5: Write data reaches the array only at a stop. If a repeated start arrives before the stop, every staged byte is dropped, no write cycle begins, and the slave answers the new address at once.
- R6: A stop that follows at least one data byte starts a write cycle of WR_CYCLES system clocks. During that cycle the slave acknowledges nothing, ignores starts and stops, and never pulls SDA low. Once the cycle ends, the slave answers a new start normally.
- R7: For an address byte with direction 1, the slave acknowledges and then shifts out the byte stored at that address, MSB first. The slave changes its SDA drive only while SCL is low, so each bit holds steady for the whole SCL high period.
- R8: When the master acknowledges a read byte, the slave sends the byte at the next address. The address counts through all 128 locations and wraps from 127 to 0.
- R9: When the master does not acknowledge a read byte, the slave releases SDA and pulls it low for nothing more until the next start.
- R10: A write that ends with a stop right after the address byte changes no stored byte and starts no write cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all logic, including the bus line synchronisers, runs on it |
| rstN | input | 1 | Asynchronous active-low reset; clears state and array to zero |
| sclIn | input | 1 | Serial clock line as seen on the bus |
| sdaIn | input | 1 | Serial data line as seen on the bus |
| sdaLowEn | output | 1 | When 1, the slave pulls SDA low; when 0, it leaves the line released |

## Verification
The assertions and the decoding assume a well-behaved master. It changes SDA only while SCL is low, and only a few system clocks after SCL has fallen. Each SCL half period is much longer than the synchroniser and edge-detector latency, so a data change is never mistaken for a start or stop. The stimulus keeps to this by using half periods of ten system clocks and by waiting three clocks after each SCL fall before it moves SDA. The only SDA edges that the master makes while SCL is high are deliberate start and stop conditions.

// File: rtl/eeprom2w_pkg.sv
package eeprom2w_pkg;

  localparam int BYTE_W  = 8;
  localparam int WADDR_W = BYTE_W - 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_RDATA,
    ST_RACK,
    ST_HOLD,
    ST_BUSY
  } phase_t;

  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic start;
    logic stop;
  } busEv_t;

  typedef struct packed {
    logic shiftIn;
    logic loadAddr;
    logic bufPush;
    logic clearBuf;
    logic commit;
    logic loadRd;
    logic shiftOut;
    logic incAddr;
  } strobe_t;

endpackage

// File: rtl/eeprom2w_dpath.sv
module eeprom2w_dpath
  import eeprom2w_pkg::*;
#(
  parameter int PAGE_BITS   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        sclIn,
  input  logic                        sdaIn,
  input  strobe_t                     stb,
  output busEv_t                      ev,
  output logic                        sdaS,
  output logic                        rwBit,
  output logic                        rdMsb,
  output logic [WADDR_W-1:0]          curAddr,
  output logic [(1<<PAGE_BITS)-1:0]   bufValid
);

  localparam int DEPTH    = 1 << WADDR_W;
  localparam int PAGE_LEN = 1 << PAGE_BITS;

  // Line synchronisers, idle value high
  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sclPrev, sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sdaS = sdaPipe[SYNC_STAGES-1];

  always_comb begin
    ev.sclRise = sclS & ~sclPrev;
    ev.sclFall = ~sclS & sclPrev;
    ev.start   = sclS & sclPrev & sdaPrev & ~sdaS;
    ev.stop    = sclS & sclPrev & ~sdaPrev & sdaS;
  end

  // Receive shifter
  logic [BYTE_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (stb.shiftIn) shiftReg <= {shiftReg[BYTE_W-2:0], sdaS};
  end

  // Address pointer and direction
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr <= '0;
      rwBit   <= 1'b0;
    end else if (stb.loadAddr) begin
      curAddr <= shiftReg[BYTE_W-1:1];
      rwBit   <= shiftReg[0];
    end else if (stb.bufPush) begin
      curAddr[PAGE_BITS-1:0] <= curAddr[PAGE_BITS-1:0] + PAGE_BITS'(1);
    end else if (stb.incAddr) begin
      curAddr <= curAddr + WADDR_W'(1);
    end
  end

  // Page staging buffer, one slot per page location
  logic [PAGE_LEN*BYTE_W-1:0] bufFlat;

  for (genvar k = 0; k < PAGE_LEN; k++) begin : gSlot
    logic [BYTE_W-1:0] slotData;
    logic              slotValid;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotData  <= '0;
        slotValid <= 1'b0;
      end else if (stb.clearBuf || stb.commit) begin
        slotValid <= 1'b0;
      end else if (stb.bufPush && curAddr[PAGE_BITS-1:0] == PAGE_BITS'(k)) begin
        slotData  <= shiftReg;
        slotValid <= 1'b1;
      end
    end

    assign bufFlat[k*BYTE_W +: BYTE_W] = slotData;
    assign bufValid[k]                 = slotValid;
  end

  // Storage array
  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (stb.commit) begin
      for (int k = 0; k < PAGE_LEN; k++) begin
        if (bufValid[k])
          mem[{curAddr[WADDR_W-1:PAGE_BITS], PAGE_BITS'(k)}] <= bufFlat[k*BYTE_W +: BYTE_W];
      end
    end
  end

  // Transmit shifter
  logic [BYTE_W-1:0] rdSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdSh <= '1;
    else if (stb.loadRd) rdSh <= mem[curAddr];
    else if (stb.shiftOut) rdSh <= {rdSh[BYTE_W-2:0], 1'b1};
  end

  assign rdMsb = rdSh[BYTE_W-1];

endmodule

// File: rtl/eeprom2w_ctrl.sv
module eeprom2w_ctrl
  import eeprom2w_pkg::*;
#(
  parameter int WR_CYCLES = 400
) (
  input  logic    clk,
  input  logic    rstN,
  input  busEv_t  ev,
  input  logic    rwBit,
  input  logic    rdMsb,
  input  logic    sdaS,
  output strobe_t stb,
  output logic    sdaLowEn,
  output phase_t  phase
);

  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  phase_t     state, nState;
  logic [3:0] bitCnt, nBit;
  logic       haveAddr, nHave;
  logic       gotData, nData;
  logic       mAck, nAck;
  logic [CNT_W-1:0] wrCnt, nWr;

  always_comb begin
    stb    = '0;
    nState = state;
    nBit   = bitCnt;
    nHave  = haveAddr;
    nData  = gotData;
    nAck   = mAck;
    nWr    = wrCnt;

    if (state == ST_BUSY) begin
      // bus ignored while the array is being written
      if (wrCnt == '0) nState = ST_IDLE;
      else nWr = wrCnt - CNT_W'(1);
    end else if (ev.start) begin
      nState       = ST_RX;
      nBit         = '0;
      nHave        = 1'b0;
      nData        = 1'b0;
      stb.clearBuf = 1'b1;
    end else if (ev.stop) begin
      if (gotData) begin
        stb.commit = 1'b1;
        nState     = ST_BUSY;
        nWr        = CNT_W'(WR_CYCLES - 1);
      end else begin
        nState = ST_IDLE;
      end
      nData = 1'b0;
    end else begin
      case (state)
        ST_RX: begin
          if (ev.sclRise && bitCnt < 4'd8) begin
            stb.shiftIn = 1'b1;
            nBit        = bitCnt + 4'd1;
          end else if (ev.sclFall && bitCnt == 4'd8) begin
            nState = ST_ACK;
            if (!haveAddr) begin
              stb.loadAddr = 1'b1;
              nHave        = 1'b1;
            end else begin
              stb.bufPush = 1'b1;
              nData       = 1'b1;
            end
          end
        end
        ST_ACK: begin
          if (ev.sclFall) begin
            nBit = '0;
            if (rwBit) begin
              stb.loadRd = 1'b1;
              nState     = ST_RDATA;
            end else begin
              nState = ST_RX;
            end
          end
        end
        ST_RDATA: begin
          if (ev.sclRise) begin
            nBit = bitCnt + 4'd1;
          end else if (ev.sclFall) begin
            if (bitCnt == 4'd8) begin
              nState      = ST_RACK;
              stb.incAddr = 1'b1;
            end else begin
              stb.shiftOut = 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (ev.sclRise) begin
            nAck = ~sdaS;
          end else if (ev.sclFall) begin
            nBit = '0;
            if (mAck) begin
              stb.loadRd = 1'b1;
              nState     = ST_RDATA;
            end else begin
              nState = ST_HOLD;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      haveAddr <= 1'b0;
      gotData  <= 1'b0;
      mAck     <= 1'b0;
      wrCnt    <= '0;
    end else begin
      state    <= nState;
      bitCnt   <= nBit;
      haveAddr <= nHave;
      gotData  <= nData;
      mAck     <= nAck;
      wrCnt    <= nWr;
    end
  end

  assign sdaLowEn = (state == ST_ACK) || (state == ST_RDATA && !rdMsb);
  assign phase    = state;

endmodule

// File: rtl/eeprom2w_slave.sv
module eeprom2w_slave
  import eeprom2w_pkg::*;
#(
  parameter int PAGE_BITS   = 2,
  parameter int WR_CYCLES   = 400,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaLowEn
);

  strobe_t                   stb;
  busEv_t                    ev;
  phase_t                    phase;
  logic                      sdaS;
  logic                      rwBit;
  logic                      rdMsb;
  logic [WADDR_W-1:0]        curAddr;
  logic [(1<<PAGE_BITS)-1:0] bufValid;

  eeprom2w_dpath #(
    .PAGE_BITS  (PAGE_BITS),
    .SYNC_STAGES(SYNC_STAGES)
  ) uDpath (
    .clk     (clk),
    .rstN    (rstN),
    .sclIn   (sclIn),
    .sdaIn   (sdaIn),
    .stb     (stb),
    .ev      (ev),
    .sdaS    (sdaS),
    .rwBit   (rwBit),
    .rdMsb   (rdMsb),
    .curAddr (curAddr),
    .bufValid(bufValid)
  );

  eeprom2w_ctrl #(
    .WR_CYCLES(WR_CYCLES)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .ev      (ev),
    .rwBit   (rwBit),
    .rdMsb   (rdMsb),
    .sdaS    (sdaS),
    .stb     (stb),
    .sdaLowEn(sdaLowEn),
    .phase   (phase)
  );

endmodule

// File: rtl/eeprom2w_chk.sv
module eeprom2w_chk
  import eeprom2w_pkg::*;
#(
  parameter int PAGE_BITS = 2,
  parameter int WR_CYCLES = 400
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        sclIn,
  input logic                        sdaLowEn,
  input phase_t                      phase,
  input strobe_t                     stb,
  input busEv_t                      ev,
  input logic [WADDR_W-1:0]          curAddr,
  input logic [(1<<PAGE_BITS)-1:0]   bufValid
);

  int busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyRun <= 0;
    else if (phase == ST_BUSY) busyRun <= busyRun + 1;
    else busyRun <= 0;
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    phase == ST_IDLE |-> !sdaLowEn);

  a_r4_page_fixed: assert property (@(posedge clk) disable iff (!rstN)
    stb.bufPush |=> curAddr[WADDR_W-1:PAGE_BITS] == $past(curAddr[WADDR_W-1:PAGE_BITS])
                 && curAddr[PAGE_BITS-1:0] == $past(curAddr[PAGE_BITS-1:0]) + PAGE_BITS'(1));

  a_r5_start_discards: assert property (@(posedge clk) disable iff (!rstN)
    (ev.start && phase != ST_BUSY) |=> bufValid == '0);

  a_r5_commit_at_stop: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |-> ev.stop);

  a_r6_busy_silent: assert property (@(posedge clk) disable iff (!rstN)
    phase == ST_BUSY |-> !sdaLowEn);

  a_r6_busy_length: assert property (@(posedge clk) disable iff (!rstN)
    (phase != ST_BUSY && $past(phase) == ST_BUSY) |-> $past(busyRun) == WR_CYCLES - 1);

  a_r7_drive_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && $past(sclIn) && $past(sclIn, 2) && $past(sclIn, 3)) |-> $stable(sdaLowEn));

  a_r8_read_advance: assert property (@(posedge clk) disable iff (!rstN)
    stb.incAddr |=> curAddr == $past(curAddr) + WADDR_W'(1));

endmodule

bind eeprom2w_slave eeprom2w_chk #(
  .PAGE_BITS(PAGE_BITS),
  .WR_CYCLES(WR_CYCLES)
) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .sclIn   (sclIn),
  .sdaLowEn(sdaLowEn),
  .phase   (phase),
  .stb     (stb),
  .ev      (ev),
  .curAddr (curAddr),
  .bufValid(bufValid)
);

// File: tb/sim_eeprom2w_slave.sv
module sim_eeprom2w_slave;

  localparam int WR = 400;
  localparam int H  = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic mLow = 1'b0;
  logic sdaLowEn;
  logic sdaLine;

  assign sdaLine = ~(mLow | sdaLowEn);

  eeprom2w_slave #(.WR_CYCLES(WR)) u0 (
    .clk     (clk),
    .rstN    (rstN),
    .sclIn   (scl),
    .sdaIn   (sdaLine),
    .sdaLowEn(sdaLowEn)
  );

  always #2ns clk = ~clk;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;
  logic [7:0] model [128];

  int highRun = 0;
  int oeHighChg = 0;
  int sdaDriven = 0;
  logic oePrev = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if (scl) highRun++;
      else highRun = 0;
      if (highRun > 4 && sdaLowEn != oePrev) oeHighChg++;
      if (sdaLowEn) sdaDriven++;
    end
    oePrev = sdaLowEn;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doStart();
    mLow = 1'b0; tick(H);
    scl = 1'b1;  tick(H);
    mLow = 1'b1; tick(H);
    scl = 1'b0;  tick(3);
  endtask

  task automatic doStop();
    mLow = 1'b1; tick(H);
    scl = 1'b1;  tick(H);
    mLow = 1'b0; tick(H);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      mLow = ~b[i]; tick(H);
      scl = 1'b1;   tick(H);
      scl = 1'b0;   tick(3);
    end
    mLow = 1'b0; tick(H);
    scl = 1'b1;  tick(H/2);
    ack = ~sdaLine;
    tick(H/2);
    scl = 1'b0;  tick(3);
  endtask

  task automatic recvByte(input bit ackIt, output logic [7:0] b);
    mLow = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      tick(H);
      scl = 1'b1; tick(H/2);
      b[i] = sdaLine;
      tick(H/2);
      scl = 1'b0; tick(3);
    end
    mLow = ackIt; tick(H);
    scl = 1'b1;   tick(H);
    scl = 1'b0;   tick(3);
    mLow = 1'b0;
  endtask

  // Expected-state model: write wraps inside the 4-byte page
  function automatic void applyWrite(input logic [6:0] a, input int n, input logic [7:0] d [8]);
    for (int i = 0; i < n; i++) begin
      logic [1:0] slot;
      slot = a[1:0] + 2'(i);
      model[{a[6:2], slot}] = d[i];
    end
  endfunction

  function automatic logic [7:0] expRead(input logic [6:0] a, input int i);
    logic [6:0] p;
    p = a + 7'(i);
    return model[p];
  endfunction

  task automatic writeSeq(input logic [6:0] a, input int n, input logic [7:0] d [8],
                          input bit waitDone, input string tag);
    bit ack;
    doStart();
    sendByte({a, 1'b0}, ack);
    chk(ack, {tag, " R2 address ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      sendByte(d[i], ack);
      chk(ack, {tag, " R2 data ack"}, ack, 1);
    end
    doStop();
    applyWrite(a, n, d);
    if (waitDone) tick(WR + 30);
  endtask

  task automatic readSeq(input logic [6:0] a, input int n, input string tag);
    bit ack;
    logic [7:0] got;
    doStart();
    sendByte({a, 1'b1}, ack);
    chk(ack, {tag, " R7 read address ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      recvByte(i != n - 1, got);
      chk(got == expRead(a, i), {tag, " R7/R8 read data"}, got, expRead(a, i));
    end
    doStop();
  endtask

  initial begin
    bit ack;
    logic [7:0] got;
    logic [7:0] d [8];

    void'($urandom(32'd4242));
    for (int i = 0; i < 128; i++) model[i] = 8'h00;
    for (int i = 0; i < 8; i++) d[i] = 8'h00;

    tick(6);
    chk(sdaLowEn == 1'b0, "R1 reset drive", sdaLowEn, 0);
    rstN = 1'b1;
    tick(10);

    // R1: byte without a start gets no ack
    sdaDriven = 0;
    scl = 1'b0; tick(H);
    sendByte(8'h2A, ack);
    chk(!ack, "R1 no ack without start", ack, 0);
    chk(sdaDriven == 0, "R1 no drive without start", sdaDriven, 0);
    doStop();

    // R3: byte write then read back
    d[0] = 8'hA5;
    writeSeq(7'h15, 1, d, 1'b1, "R3 byte write");
    readSeq(7'h15, 1, "R3 readback");

    // R6: bus locked during write cycle
    d[0] = 8'h3C;
    writeSeq(7'h40, 1, d, 1'b0, "R6 write");
    sdaDriven = 0;
    doStart();
    sendByte({7'h40, 1'b1}, ack);
    chk(!ack, "R6 no ack while busy", ack, 0);
    chk(sdaDriven == 0, "R6 no drive while busy", sdaDriven, 0);
    doStop();
    tick(WR + 30);
    readSeq(7'h40, 1, "R6 after busy");

    // R4: full page starting mid-page
    d[0] = 8'h11; d[1] = 8'h22; d[2] = 8'h33; d[3] = 8'h44;
    writeSeq(7'h22, 4, d, 1'b1, "R4 page");
    chk(model[7'h20] == 8'h33, "R4 wrap model", model[7'h20], 8'h33);
    readSeq(7'h20, 4, "R4 page read");

    // R4: more than a page overwrites within the page
    d[0] = 8'h51; d[1] = 8'h52; d[2] = 8'h53; d[3] = 8'h54; d[4] = 8'h55; d[5] = 8'h56;
    writeSeq(7'h31, 6, d, 1'b1, "R4 overrun");
    readSeq(7'h30, 5, "R4 overrun read");

    // R5: repeated start discards staged bytes
    doStart();
    sendByte({7'h50, 1'b0}, ack);
    chk(ack, "R5 address ack", ack, 1);
    sendByte(8'h99, ack);
    sendByte(8'h98, ack);
    doStart();
    sendByte({7'h50, 1'b1}, ack);
    chk(ack, "R5 ack right after abort", ack, 1);
    recvByte(1'b0, got);
    chk(got == model[7'h50], "R5 data unchanged", got, model[7'h50]);
    doStop();
    tick(H);
    readSeq(7'h51, 1, "R5 second byte unchanged");

    // R10: address-only write
    doStart();
    sendByte({7'h15, 1'b0}, ack);
    chk(ack, "R10 address ack", ack, 1);
    doStop();
    tick(H);
    readSeq(7'h15, 1, "R10 no write cycle");

    // R8: sequential read across the top of the array
    d[0] = 8'hAB; d[1] = 8'hCD;
    writeSeq(7'h7E, 2, d, 1'b1, "R8 setup hi");
    d[0] = 8'hEF;
    writeSeq(7'h00, 1, d, 1'b1, "R8 setup lo");
    readSeq(7'h7E, 3, "R8 wrap read");

    // R9: after a nack the slave stays off the line
    doStart();
    sendByte({7'h15, 1'b1}, ack);
    recvByte(1'b0, got);
    chk(got == model[7'h15], "R9 data before nack", got, model[7'h15]);
    sdaDriven = 0;
    sendByte(8'hFF, ack);
    chk(!ack, "R9 no ack after nack", ack, 0);
    chk(sdaDriven == 0, "R9 released after nack", sdaDriven, 0);
    doStop();

    // Random writes and reads
    for (int it = 0; it < 10; it++) begin
      logic [6:0] a;
      int n;
      a = 7'($urandom_range(0, 127));
      n = $urandom_range(1, 6);
      for (int i = 0; i < 8; i++) d[i] = 8'($urandom_range(0, 255));
      writeSeq(a, n, d, 1'b1, "R4 random write");
      a = 7'($urandom_range(0, 127));
      n = $urandom_range(1, 5);
      readSeq(a, n, "R8 random read");
    end

    chk(oeHighChg == 0, "R7 drive changed with SCL high", oeHighChg, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

endmodule